// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of up to 32 general-purpose pins behind a simple word-wide register bus. Software drives pins through an output data register that is only changed by separate set and clear writes, picks per-pin direction, and reads back the synchronised pin levels. Each pin also feeds an event detector. The detector is programmed per pin for edge or level sensing, and for either positive or negative logic.

Detected events land in a per-pin pending-status register. Software clears these bits by writing ones. Per-pin interrupt enables are changed only through a write-one-to-set register and a write-one-to-clear register, so no read-modify-write is ever needed. One interrupt line, the OR of all pending and enabled bits, goes to a parent controller.

Bus reads are combinational from the address. Writes take effect at the rising clock edge on which the write strobe is high. Word addresses: 0 input levels, 1 output set (reads output data), 2 output clear, 3 direction, 4 enable set (reads enable mask), 5 enable clear, 6 status, 7 trigger mode, 8 handling-kind bit, 9 polarity.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, output data, direction, enables and status are all zero, and the interrupt line is low. The trigger-mode, handling-kind and polarity registers reset to all ones (rising-edge on every pin).
- R2: A read of address 0 returns each pin's level after a two-flop synchroniser, so a pin change shows up on the read two rising edges after it is applied.
- R3: A write to address 1 sets the output bits given as ones, and a write to address 2 clears them; zero bits leave a pin unchanged. A read of address 1 returns the output data, and pinOut drives it.
- R4: Address 3 is the direction register, where bit n = 1 makes pin n an output; pinOe reflects it.
- R5: Writing ones to address 4 enables the interrupt of those pins; other enables are unchanged. A read of address 4 returns the enable mask.
- R6: Writing ones to address 5 disables those pins' interrupts; other enables are unchanged. Address 5 reads zero.
- R7: In edge mode (trigger bit 1), a synchronised rising edge (polarity bit 1) or falling edge (polarity bit 0) sets the sticky status bit even when the pin is disabled. An edge of the other direction does nothing.
- R8: Address 6 reads the status bits. Writing a one to bit n clears a pending edge-mode status bit n.
- R9: In level mode (trigger bit 0), status bit n follows the active level (high for polarity 1, low for polarity 0) every cycle. A clear write has no lasting effect while the level stays active.
- R10: When a new edge on pin n is detected in the same cycle as a clear write to bit n, the status bit stays set.
- R11: irqOut is high exactly when some pin has both its status bit and its enable bit set.
- R12: Addresses 7, 8 and 9 are read/write trigger-mode, handling-kind and polarity registers. Addresses above 9 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register word address |
| busWrData | input | BUS_W | Write data |
| busWe | input | 1 | Write strobe |
| busRdData | output | BUS_W | Read data for busAddr |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Output data to pins |
| pinOe | output | NUM_PINS | Per-pin output enable |
| irqOut | output | 1 | Interrupt to parent controller |

## Verification
The bench drives a clear write in exactly the cycle in which a new edge is detected. A design that lets the clear win would lose that event. A pin with negative polarity gets both a rising and a falling edge, which catches detectors that ignore polarity. A level-mode pin is cleared while its level is still active and then released. This exposes designs that make a level status sticky, or that let the clear stick. Events on disabled pins must still set status while the interrupt line stays low, which catches designs that gate detection, rather than the interrupt, by the enable.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RG_IN   = 4'd0,
    RG_OSET = 4'd1,
    RG_OCLR = 4'd2,
    RG_DIR  = 4'd3,
    RG_ESET = 4'd4,
    RG_ECLR = 4'd5,
    RG_STS  = 4'd6,
    RG_TRIG = 4'd7,
    RG_HDL  = 4'd8,
    RG_POL  = 4'd9
  } regIdx_e;

  localparam logic [REG_AW-1:0] LAST_REG = 4'd9;

  typedef struct packed {
    logic outSet;
    logic outClr;
    logic dirWr;
    logic ienSet;
    logic ienClr;
    logic stsClr;
    logic trigWr;
    logic hdlWr;
    logic polWr;
  } strobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          stb,
  output regIdx_e           rdSel,
  output logic              rdValid
);
  logic hit;
  assign hit     = busAddr <= LAST_REG;
  assign rdValid = hit;
  assign rdSel   = hit ? regIdx_e'(busAddr) : RG_IN;

  always_comb begin
    stb = '0;
    if (busWe && hit) begin
      case (regIdx_e'(busAddr))
        RG_OSET: stb.outSet = 1'b1;
        RG_OCLR: stb.outClr = 1'b1;
        RG_DIR:  stb.dirWr  = 1'b1;
        RG_ESET: stb.ienSet = 1'b1;
        RG_ECLR: stb.ienClr = 1'b1;
        RG_STS:  stb.stsClr = 1'b1;
        RG_TRIG: stb.trigWr = 1'b1;
        RG_HDL:  stb.hdlWr  = 1'b1;
        RG_POL:  stb.polWr  = 1'b1;
        default: stb = '0;
      endcase
    end
  end

  // R12: at most one register is written per bus cycle
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  // R12: an unmapped address never produces a write strobe
  p_unmapped_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > LAST_REG) |-> (stb == '0));
endmodule

// File: rtl/gpio_irq_datapath.sv
`timescale 1ns/1ps
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  regIdx_e             rdSel,
  input  logic                rdValid,
  input  logic [BUS_W-1:0]    wrData,
  output logic [BUS_W-1:0]    rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  localparam int PW = NUM_PINS;

  logic [PW-1:0] wMask;
  logic [PW-1:0] syncQ [SYNC_STAGES];
  logic [PW-1:0] pinNow, prevQ;
  logic [PW-1:0] outQ, dirQ, ienQ, stsQ, trigQ, hdlQ, polQ;
  logic [PW-1:0] edgeHit, levelHit, clrMask;

  assign wMask = wrData[PW-1:0];

  // input synchroniser chain, then one more flop for edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end
  assign pinNow = syncQ[SYNC_STAGES-1];

  // configuration and data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      dirQ  <= '0;
      ienQ  <= '0;
      trigQ <= '1;
      hdlQ  <= '1;
      polQ  <= '1;
    end else begin
      if (stb.outSet) outQ <= outQ | wMask;
      if (stb.outClr) outQ <= outQ & ~wMask;
      if (stb.dirWr)  dirQ <= wMask;
      if (stb.ienSet) ienQ <= ienQ | wMask;
      if (stb.ienClr) ienQ <= ienQ & ~wMask;
      if (stb.trigWr) trigQ <= wMask;
      if (stb.hdlWr)  hdlQ  <= wMask;
      if (stb.polWr)  polQ  <= wMask;
    end
  end

  assign edgeHit  = (pinNow & ~prevQ & polQ) | (~pinNow & prevQ & ~polQ);
  assign levelHit = ~(pinNow ^ polQ);
  assign clrMask  = stb.stsClr ? wMask : '0;

  // per-pin pending cell: sticky in edge mode, transparent in level mode
  for (genvar i = 0; i < PW; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         stsQ[i] <= 1'b0;
      else if (trigQ[i]) stsQ[i] <= (stsQ[i] & ~clrMask[i]) | edgeHit[i];
      else               stsQ[i] <= levelHit[i];
    end
  end

  assign irqOut = |(stsQ & ienQ);
  assign pinOut = outQ;
  assign pinOe  = dirQ;

  always_comb begin
    rdData = '0;
    if (rdValid) begin
      case (rdSel)
        RG_IN:   rdData[PW-1:0] = pinNow;
        RG_OSET: rdData[PW-1:0] = outQ;
        RG_DIR:  rdData[PW-1:0] = dirQ;
        RG_ESET: rdData[PW-1:0] = ienQ;
        RG_STS:  rdData[PW-1:0] = stsQ;
        RG_TRIG: rdData[PW-1:0] = trigQ;
        RG_HDL:  rdData[PW-1:0] = hdlQ;
        RG_POL:  rdData[PW-1:0] = polQ;
        default: rdData = '0;
      endcase
    end
  end

  // R3: set bits are present in the output after a set write
  p_out_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outSet) |=> ((outQ & $past(wMask)) == $past(wMask)));
  // R5: enable-set bits are on after the write
  p_ien_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ienSet) |=> ((ienQ & $past(wMask)) == $past(wMask)));
  // R6: enable-clear bits are off after the write
  p_ien_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ienClr) |=> ((ienQ & $past(wMask)) == '0));
  // R7: a pending edge-mode bit stays set unless cleared
  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((stsQ & $past(stsQ & trigQ & ~clrMask)) == $past(stsQ & trigQ & ~clrMask)));
  // R10: a fresh edge survives a same-cycle clear
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((stsQ & $past(edgeHit & trigQ)) == $past(edgeHit & trigQ)));
  // R11: interrupt implies some pending bit
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stsQ != '0));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_AW-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  input  logic                busWe,
  output logic [BUS_W-1:0]    busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  strobes_t stb;
  regIdx_e  rdSel;
  logic     rdValid;

  gpio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .stb(stb), .rdSel(rdSel), .rdValid(rdValid)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .rdValid(rdValid),
    .wrData(busWrData), .rdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  busAddr;
  logic [31:0] busWrData;
  logic        busWe;
  logic [31:0] busRdData;
  logic [31:0] pinIn;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mS1, mS2, mPv, mSts, mIen, mOut, mDir, mTrig, mHdl, mPol;

  always @(posedge clk) begin : model
    logic [31:0] nSts;
    bit ev, clr;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPv = 0; mSts = 0; mIen = 0; mOut = 0; mDir = 0;
      mTrig = '1; mHdl = '1; mPol = '1;
    end else begin
      for (int i = 0; i < 32; i++) begin
        clr = busWe && busAddr == 4'd6 && busWrData[i];
        if (mPol[i]) ev = mS2[i] && !mPv[i];
        else         ev = !mS2[i] && mPv[i];
        if (mTrig[i]) nSts[i] = (mSts[i] && !clr) || ev;
        else          nSts[i] = (mS2[i] == mPol[i]);
      end
      mSts = nSts;
      mPv = mS2; mS2 = mS1; mS1 = pinIn;
      if (busWe) begin
        case (busAddr)
          4'd1: mOut = mOut | busWrData;
          4'd2: mOut = mOut & ~busWrData;
          4'd3: mDir = busWrData;
          4'd4: mIen = mIen | busWrData;
          4'd5: mIen = mIen & ~busWrData;
          4'd7: mTrig = busWrData;
          4'd8: mHdl = busWrData;
          4'd9: mPol = busWrData;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a)
      4'd0: return mS2;
      4'd1: return mOut;
      4'd3: return mDir;
      4'd4: return mIen;
      4'd6: return mSts;
      4'd7: return mTrig;
      4'd8: return mHdl;
      4'd9: return mPol;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [3:0] a);
    case (a)
      4'd0: return "R2 read";
      4'd1, 4'd2: return "R3 read";
      4'd3: return "R4 read";
      4'd4: return "R5 read";
      4'd5: return "R6 read";
      4'd6: return "R8 read";
      default: return "R12 read";
    endcase
  endfunction

  // every-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #3;
    if (rstN === 1'b1 && !done) begin
      check(tagFor(busAddr), busRdData, expRead(busAddr));
      check("R3 pinOut", pinOut, mOut);
      check("R4 pinOe", pinOe, mDir);
      check("R11 irq", {31'b0, irqOut}, {31'b0, |(mSts & mIen)});
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readChk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    busAddr = a;
    @(posedge clk);
    #3;
    check(tag, busRdData, exp);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; busAddr = 0; busWrData = 0; busWe = 0; pinIn = 0;
    settle(3);
    rstN = 1'b1;
    // R1 reset state
    readChk("R1 trig", 4'd7, 32'hFFFF_FFFF);
    readChk("R1 hdl", 4'd8, 32'hFFFF_FFFF);
    readChk("R1 pol", 4'd9, 32'hFFFF_FFFF);
    readChk("R1 sts", 4'd6, 32'h0);
    readChk("R1 ien", 4'd4, 32'h0);
    readChk("R1 out", 4'd1, 32'h0);
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R3 set / clear
    busWrite(4'd1, 32'h0000_00F0);
    busWrite(4'd1, 32'h0000_0003);
    readChk("R3 set", 4'd1, 32'h0000_00F3);
    busWrite(4'd2, 32'h0000_0010);
    readChk("R3 clear", 4'd1, 32'h0000_00E3);
    check("R3 pinOut", pinOut, 32'h0000_00E3);

    // R4 direction
    busWrite(4'd3, 32'hFF00_FF00);
    check("R4 pinOe", pinOe, 32'hFF00_FF00);

    // R2 / R7: rising edges on disabled pins
    pinIn = 32'h0000_00A5;
    settle(4);
    readChk("R2 sync", 4'd0, 32'h0000_00A5);
    readChk("R7 disabled edge", 4'd6, 32'h0000_00A5);
    check("R11 masked", {31'b0, irqOut}, 32'h0);

    // R5 / R6 / R11
    busWrite(4'd4, 32'h1);
    check("R11 enabled", {31'b0, irqOut}, 32'h1);
    busWrite(4'd4, 32'h4);
    readChk("R5 set", 4'd4, 32'h5);
    busWrite(4'd5, 32'h1);
    readChk("R6 clear", 4'd4, 32'h4);
    check("R11 other pin", {31'b0, irqOut}, 32'h1);

    // R8 clear
    busWrite(4'd6, 32'h0000_00A5);
    readChk("R8 ack", 4'd6, 32'h0);
    check("R11 quiet", {31'b0, irqOut}, 32'h0);

    // R7 negative polarity on pin 1
    busWrite(4'd9, 32'hFFFF_FFFD);
    pinIn = 32'h0000_00A7;
    settle(4);
    readChk("R7 wrong edge", 4'd6, 32'h0);
    pinIn = 32'h0000_00A5;
    settle(4);
    readChk("R7 falling", 4'd6, 32'h2);

    // R9 level mode on pin 3, high active
    busWrite(4'd7, 32'hFFFF_FFF7);
    readChk("R9 inactive", 4'd6, 32'h2);
    pinIn = 32'h0000_00AD;
    settle(4);
    readChk("R9 active", 4'd6, 32'hA);
    busWrite(4'd6, 32'h8);
    settle(2);
    readChk("R9 clear ignored", 4'd6, 32'hA);
    pinIn = 32'h0000_00A5;
    settle(4);
    readChk("R9 follows", 4'd6, 32'h2);
    busWrite(4'd6, 32'h2);
    readChk("R8 ack2", 4'd6, 32'h0);

    // R10 edge on pin 4 meets a clear in the same cycle
    pinIn = 32'h0000_00B5;
    @(negedge clk);
    @(negedge clk);
    busAddr = 4'd6; busWrData = 32'h10; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    readChk("R10 edge wins", 4'd6, 32'h10);
    busWrite(4'd6, 32'h10);
    readChk("R8 ack3", 4'd6, 32'h0);

    // R12 config registers and unmapped space
    busWrite(4'd8, 32'h0F0F_0F0F);
    readChk("R12 hdl", 4'd8, 32'h0F0F_0F0F);
    busWrite(4'd12, 32'hFFFF_FFFF);
    readChk("R12 unmapped", 4'd12, 32'h0);
    readChk("R12 out kept", 4'd1, 32'h0000_00E3);
    readChk("R12 ien kept", 4'd4, 32'h4);
    readChk("R12 clr reads 0", 4'd2, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule